// File: doc/BRIEF.md
# Two-Channel Time-Shared Recursive Filter

This block runs one second-order recursive filter, y(n) = x(n) + a·y(n-2), for two independent audio channels over a single datapath. The channels take turns on alternate clock cycles. The clock after a channel-0 sample carries a channel-1 sample, and the clock after that carries channel 0 again. Every delay of the one-channel filter is doubled, so the feedback loop holds four sample slots instead of two. Each channel then sees its own history and nothing of the other channel.

One of the four loop slots is moved past the coefficient multiplier. The stored value in that slot is the rounded product rather than a raw sample. This takes the multiplier off the path that ends at the output adder. The coefficient is a fixed parameter in signed Q1.14. Samples are 16-bit signed. The output is registered and leaves one clock after its input, with the same channel tag.

Top module: `iir2s_top`

## Requirements
- R1: For each channel c, with its samples numbered n = 0, 1, 2, ..., the output is y_c(n) = clamp(x_c(n) + round(COEF·y_c(n-2) / 2^14)). COEF defaults to 13107 (about 0.8). History before the first sample after reset is zero.
- R2: The result for an input presented at one rising edge appears on `out_data` after that edge. It is held until the next edge, and `out_ch` carries the input's tag during the same cycle.
- R3: The two channels are independent. The outputs of one channel depend only on the samples tagged with that channel.
- R4: The product p = COEF·y is rounded to nearest with halves going up, as floor(p/2^14 + 1/2). This happens before the input sample is added.
- R5: The sum is clamped to the range -32768 to 32767 before it is output and stored in the loop.
- R6: While `rst_n` is low, `out_data` and `out_ch` read 0 and all loop history is cleared. After release, both channels restart from zero history.
- R7: The input tag `in_ch` must toggle on every clock after reset, where 0 means channel 0 and 1 means channel 1. The output tag therefore also toggles on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ch | input | 1 | Channel tag of the input sample |
| in_data | input | 16 | Signed input sample |
| out_ch | output | 1 | Channel tag of the output sample |
| out_data | output | 16 | Signed filtered sample |

## Verification
A wrong register in the loop shows up in a channel's output no later than four clocks after the sample that wrote it. The shared loop alternates between channels, so a slot that is off by one position leaks one channel's history into the other's output. Driving an impulse on one channel and silence on the other exposes this within a few clocks. Rounding and clamping faults need particular stimulus to show. A rounding error appears in the least significant bit once the history is nonzero. A clamping fault appears only when a channel is driven with a held extreme value.

// File: rtl/iir2s_pkg.sv
package iir2s_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int unsigned TAG_RESET = 0;
endpackage

// File: rtl/iir2s_hist.sv
module iir2s_hist #(
  parameter int DW    = 16,
  parameter int DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] d_in,
  output logic signed [DW-1:0] d_tail
);
  logic signed [DW-1:0] stage_q [DEPTH];
  logic signed [DW-1:0] stage_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb stage_d[g] = d_in;
    end else begin : g_body
      always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign d_tail = stage_q[DEPTH-1];
endmodule

// File: rtl/iir2s_fb.sv
module iir2s_fb #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter logic signed [CW-1:0] COEF = 16'sd13107,
  localparam int PW  = DW + CW,
  localparam int FBW = PW + 1 - FRAC
) (
  input  logic signed [DW-1:0]  y_old,
  output logic signed [FBW-1:0] fb
);
  logic signed [PW-1:0] prod;
  logic signed [PW:0]   biased;

  always_comb begin
    prod   = y_old * COEF;
    biased = PW'(prod) + (PW+1)'(1 <<< (FRAC-1));
    fb     = biased[PW:FRAC];
  end
endmodule

// File: rtl/iir2s_top.sv
module iir2s_top #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter logic signed [CW-1:0] COEF = 16'sd13107,
  parameter int SLOW  = 2,
  parameter int ORDER = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_ch,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_ch,
  output logic signed [DW-1:0] out_data
);
  import iir2s_pkg::*;

  localparam int LOOP   = SLOW * ORDER;
  localparam int HDEPTH = LOOP - 1;
  localparam int FBW    = DW + CW + 1 - FRAC;
  localparam int SW     = FBW + 1;
  localparam logic signed [SW-1:0] YMAX = SW'((1 <<< (DW-1)) - 1);
  localparam logic signed [SW-1:0] YMIN = -SW'(1 <<< (DW-1));

  logic signed [FBW-1:0] fb_q, fb_d;
  logic signed [SW-1:0]  sum;
  logic signed [DW-1:0]  y_new, tail;
  chan_e                 ch_q, ch_d;
  logic signed [DW-1:0]  out_q, out_d;

  always_comb begin
    sum = SW'(in_data) + SW'(fb_q);
    if (sum > YMAX)      y_new = YMAX[DW-1:0];
    else if (sum < YMIN) y_new = YMIN[DW-1:0];
    else                 y_new = sum[DW-1:0];
  end

  iir2s_hist #(.DW(DW), .DEPTH(HDEPTH)) i_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (y_new),
    .d_tail (tail)
  );

  iir2s_fb #(.DW(DW), .CW(CW), .FRAC(FRAC), .COEF(COEF)) i_fb (
    .y_old (tail),
    .fb    (fb_d)
  );

  always_comb begin
    out_d = y_new;
    ch_d  = chan_e'(in_ch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q  <= '0;
      out_q <= '0;
      ch_q  <= chan_e'(TAG_RESET);
    end else begin
      fb_q  <= fb_d;
      out_q <= out_d;
      ch_q  <= ch_d;
    end
  end

  assign out_data = out_q;
  assign out_ch   = ch_q;
endmodule

// File: rtl/iir2s_chk.sv
module iir2s_chk #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter logic signed [CW-1:0] COEF = 16'sd13107,
  parameter int SLOW  = 2,
  parameter int ORDER = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ch,
  input logic signed [DW-1:0] in_data,
  input logic                 out_ch,
  input logic signed [DW-1:0] out_data
);
  localparam int LOOP = SLOW * ORDER;
  localparam longint HI = (64'sd1 <<< (DW-1)) - 1;
  localparam longint LO = -(64'sd1 <<< (DW-1));

  logic                 seen;
  logic                 ch_prev;
  logic signed [DW-1:0] x_prev;
  logic signed [DW-1:0] shadow [LOOP];
  longint               raw, expect_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      ch_prev <= 1'b0;
      x_prev  <= '0;
      for (int i = 0; i < LOOP; i++) shadow[i] <= '0;
    end else begin
      seen      <= 1'b1;
      ch_prev   <= in_ch;
      x_prev    <= in_data;
      shadow[0] <= out_data;
      for (int i = 1; i < LOOP; i++) shadow[i] <= shadow[i-1];
    end
  end

  always_comb begin
    raw = longint'(x_prev)
        + ((longint'(shadow[LOOP-1]) * longint'(COEF) + (64'sd1 <<< (FRAC-1))) >>> FRAC);
    expect_y = (raw > HI) ? HI : ((raw < LO) ? LO : raw);
  end

  // R1: each output follows the recurrence against the same channel's output four slots back
  a_r1_recurrence: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> longint'(out_data) == expect_y);

  // R2: the output tag is the tag that came in one clock earlier
  a_r2_tag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> out_ch == ch_prev);

  // R3: a channel with silent history and silent input stays silent
  a_r3_silent_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && shadow[LOOP-1] == '0 && x_prev == '0) |-> out_data == '0);

  // R5: an overflowing sum sits at the positive limit
  a_r5_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && raw > HI) |-> longint'(out_data) == HI);

  // R7: the input tag toggles every clock once out of reset
  a_r7_tag_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> in_ch != ch_prev);
endmodule

bind iir2s_top iir2s_chk #(
  .DW(DW), .CW(CW), .FRAC(FRAC), .COEF(COEF), .SLOW(SLOW), .ORDER(ORDER)
) i_iir2s_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ch    (in_ch),
  .in_data  (in_data),
  .out_ch   (out_ch),
  .out_data (out_data)
);

// File: tb/test_iir2s_top.sv
module test_iir2s_top;
  localparam int COEF = 13107;

  logic               clk;
  logic               rst_n;
  logic               in_ch;
  logic signed [15:0] in_data;
  logic               out_ch;
  logic signed [15:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int yh1 [2];
  int yh2 [2];
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit done = 0;

  iir2s_top i_iir2s_top (
    .clk(clk), .rst_n(rst_n), .in_ch(in_ch), .in_data(in_data),
    .out_ch(out_ch), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ref_round(input int p);
    return $rtoi($floor(real'(p) / 16384.0 + 0.5));
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_ref();
    for (int c = 0; c < 2; c++) begin
      yh1[c] = 0;
      yh2[c] = 0;
    end
  endtask

  // drive one sample at a falling edge, check its result one falling edge later
  task automatic push(input string req, input int c, input int x);
    int y;
    in_ch   = c[0];
    in_data = 16'(x);
    y = clamp16(x + ref_round(COEF * yh2[c]));
    yh2[c] = yh1[c];
    yh1[c] = y;
    @(negedge clk);
    check(req, int'(out_data), y);
    check("R2 tag", int'(out_ch), c);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6 data in reset", int'(out_data), 0);
    check("R6 tag in reset", int'(out_ch), 0);
    clear_ref();
    rst_n = 1'b1;
  endtask

  initial begin
    in_ch = 1'b0;
    in_data = '0;
    clear_ref();
    @(negedge clk);
    do_reset();

    // R3: impulse on channel 0, silence on channel 1
    for (int i = 0; i < 24; i++) begin
      push("R3 impulse ch0", 0, (i == 0) ? 1000 : 0);
      push("R3 silent ch1", 1, 0);
    end
    // R3: impulse on channel 1 while channel 0 still decays
    for (int i = 0; i < 24; i++) begin
      push("R3 decay ch0", 0, 0);
      push("R3 impulse ch1", 1, (i == 0) ? -2000 : 0);
    end
    // R1: unrelated pseudo-random streams on both channels
    for (int i = 0; i < 800; i++) begin
      lfsr = next_rand(lfsr);
      push("R1 random ch0", 0, int'($signed(lfsr[15:0])) >>> 2);
      lfsr = next_rand(lfsr);
      push("R1 random ch1", 1, int'($signed(lfsr[31:16])) >>> 3);
    end
    // R4: small-value sweep where rounding decides the low bits
    for (int v = -300; v <= 300; v++) begin
      push("R4 rounding ch0", 0, v);
      push("R4 rounding ch1", 1, -v / 3);
    end
    // R5: held extremes drive both channels into clamping
    for (int i = 0; i < 20; i++) begin
      push("R5 clip high ch0", 0, 32767);
      push("R5 clip low ch1", 1, -32768);
    end
    for (int i = 0; i < 20; i++) begin
      push("R5 clip recover ch0", 0, -32768);
      push("R5 clip recover ch1", 1, 32767);
    end
    // R6: reset in the middle of a loaded history
    do_reset();
    for (int i = 0; i < 6; i++) begin
      push("R6 history cleared ch0", 0, 0);
      push("R6 history cleared ch1", 1, 0);
    end
    // R7: tag keeps alternating across a final burst
    for (int i = 0; i < 16; i++) begin
      push("R7 burst ch0", 0, 500 - i * 40);
      push("R7 burst ch1", 1, i * 90 - 700);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule